// File: doc/BRIEF.md
# Supply Voltage Crossing Interrupt Detector

This block watches the digital output of a supply comparator, which reads 1 while the supply sits above a fixed detection threshold and 0 while it sits below. The level is brought into the clock domain by a synchronizer. It is then sampled on a prescaler tick whose period is a power-of-two multiple of the CPU clock, picked by a two-bit field. A new level is accepted only when two consecutive ticks agree. Each accepted change, whichever way it goes, sets a sticky status flag. When the flag moves from 0 to 1 with the interrupt enabled, the block emits a one-cycle interrupt request.

Software configures the block through a single control write, which also carries the flag-clear bit. A second enable lets an upward crossing wake the device from its stop state. That path raises a request whatever the flag holds, and it drives a wake level that stays high until the stop indication drops.

Top module: `vdet_xing_irq`

## Requirements
- R1: After reset, `cfg_o` is 0 (both enables off, divider field 00), and `flag_o`, `irq_o` and `wake_o` are all 0.
- R2: A cycle with `ctrl_we_i`=1 loads `ctrl_wdata_i[0]` as the interrupt enable, `[1]` as the stop-wake enable and `[3:2]` as the divider field. `cfg_o` then shows those fields at the same bit positions.
- R3: The divider field values 00, 01, 10 and 11 give one sampling tick every 8, 16, 32 and 64 clock cycles. A write that changes the field restarts the count, so the first tick after it comes a full period after the write edge.
- R4: After the two-flop synchronizer, a new comparator level is accepted only when it is seen on two consecutive ticks. A level that is seen on a single tick is rejected and sets nothing.
- R5: An accepted change in either direction sets `flag_o`. If the comparator changes just after a restarting write edge, the flag goes to 1 exactly 2·N cycles after that edge, where N is the selected division ratio.
- R6: Hardware never clears `flag_o`. Only a control write with bit 4 = 0 clears it. A write with bit 4 = 1 leaves it unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R7: `irq_o` is a one-cycle pulse, issued in the cycle the flag goes from 0 to 1, and only while the interrupt enable is 1. With the enable at 0 the flag still sets but no pulse appears.
- R8: While `stop_mode_i`=1 with both enables at 1, an accepted change to above-threshold raises `irq_o` and sets `wake_o`, even when `flag_o` is already 1.
- R9: `wake_o` stays at 1 while `stop_mode_i` stays 1, and returns to 0 on the clock edge after `stop_mode_i` falls.
- R10: In stop mode, an accepted change to below-threshold, or any change while the stop-wake enable is 0, sets neither `wake_o` nor a request through the wake path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above_i | input | 1 | Asynchronous comparator level, 1 = supply above threshold |
| stop_mode_i | input | 1 | Device is in its stop state |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 5 | [0] interrupt enable, [1] stop-wake enable, [3:2] divider field, [4] flag write (0 clears) |
| cfg_o | output | 4 | Current control fields, same layout as write bits [3:0] |
| flag_o | output | 1 | Sticky crossing status flag |
| irq_o | output | 1 | One-cycle interrupt request |
| wake_o | output | 1 | Stop-mode wake level |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, a minimum ratio of 8, and a reset level of "above". With these values every divider setting, from 8 up to 64 cycles, can be timed to the exact cycle after a restarting write. The default reset level makes the first downward crossing an accepted event. It sweeps every divider code in both crossing directions, times the flag and request to the exact cycle, rejects a single-tick glitch, and drives the stop-wake path with the flag already set.

// File: rtl/vdet_pkg.sv
package vdet_pkg;

    localparam int SEL_W        = 2;
    localparam int DIV_LOG2_MIN = 3;
    localparam int DIV_LOG2_MAX = DIV_LOG2_MIN + (1 << SEL_W) - 1;
    localparam int CNT_W        = DIV_LOG2_MAX;

    typedef struct packed {
        logic [SEL_W-1:0] div_sel;
        logic             wake_en;
        logic             irq_en;
    } vdet_cfg_t;

    typedef struct packed {
        logic      flag_keep;
        vdet_cfg_t cfg;
    } vdet_wr_t;

    localparam int CFG_W = $bits(vdet_cfg_t);
    localparam int WR_W  = $bits(vdet_wr_t);

    typedef enum logic [1:0] {
        XING_NONE = 2'b00,
        XING_RISE = 2'b01,
        XING_FALL = 2'b10
    } vdet_xing_e;

    function automatic logic [CNT_W-1:0] div_last(input logic [SEL_W-1:0] sel);
        logic [CNT_W:0] span;
        span = (CNT_W+1)'(1) << (DIV_LOG2_MIN + int'(sel));
        return CNT_W'(span - (CNT_W+1)'(1));
    endfunction

endpackage

// File: rtl/vdet_sync.sv
module vdet_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= RESET_VAL;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RESET_VAL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/vdet_prescaler.sv
module vdet_prescaler
    import vdet_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last   = div_last(sel_i);
    assign tick_o = (cnt_q == last) && !restart_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i || tick_o) cnt_q <= '0;
        else                            cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o); // R3
endmodule

// File: rtl/vdet_filter.sv
module vdet_filter
    import vdet_pkg::*;
#(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       lvl_i,
    output logic       level_o,
    output vdet_xing_e xing_o
);
    logic last_q;
    logic acc_q;
    logic accept;

    assign accept = tick_i && (lvl_i == last_q) && (lvl_i != acc_q);

    always_comb begin
        xing_o = XING_NONE;
        if (accept) xing_o = lvl_i ? XING_RISE : XING_FALL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= RESET_VAL;
            acc_q  <= RESET_VAL;
        end else if (tick_i) begin
            last_q <= lvl_i;
            if (accept) acc_q <= lvl_i;
        end
    end

    assign level_o = acc_q;

    AST_ACCEPT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (acc_q != $past(acc_q)) |-> $past(tick_i)); // R4
endmodule

// File: rtl/vdet_xing_irq.sv
module vdet_xing_irq
    import vdet_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_above_i,
    input  logic            stop_mode_i,
    input  logic            ctrl_we_i,
    input  logic [WR_W-1:0] ctrl_wdata_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic            flag_o,
    output logic            irq_o,
    output logic            wake_o
);
    vdet_wr_t   wr;
    vdet_cfg_t  cfg_q;
    vdet_xing_e xing;
    logic       lvl_sync;
    logic       lvl_acc;
    logic       tick;
    logic       restart;
    logic       set_evt;
    logic       clr_evt;
    logic       wake_evt;
    logic       flag_q;
    logic       irq_q;
    logic       wake_q;

    assign wr      = vdet_wr_t'(ctrl_wdata_i);
    assign restart = ctrl_we_i && (wr.cfg.div_sel != cfg_q.div_sel);

    always_ff @(posedge clk) begin
        if (rst)            cfg_q <= '0;
        else if (ctrl_we_i) cfg_q <= wr.cfg;
    end

    vdet_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(RESET_LEVEL)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cmp_above_i),
        .sync_o  (lvl_sync)
    );

    vdet_prescaler u_presc (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart),
        .sel_i     (cfg_q.div_sel),
        .tick_o    (tick)
    );

    vdet_filter #(.RESET_VAL(RESET_LEVEL)) u_filt (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick),
        .lvl_i   (lvl_sync),
        .level_o (lvl_acc),
        .xing_o  (xing)
    );

    assign set_evt  = (xing != XING_NONE);
    assign clr_evt  = ctrl_we_i && !wr.flag_keep;
    assign wake_evt = (xing == XING_RISE) && stop_mode_i && cfg_q.wake_en && cfg_q.irq_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            if (set_evt)      flag_q <= 1'b1;
            else if (clr_evt) flag_q <= 1'b0;
            irq_q  <= cfg_q.irq_en && ((set_evt && !flag_q) || wake_evt);
            wake_q <= stop_mode_i && (wake_q || wake_evt);
        end
    end

    assign cfg_o  = cfg_q;
    assign flag_o = flag_q;
    assign irq_o  = irq_q;
    assign wake_o = wake_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_evt) |=> flag_q); // R6
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q); // R7
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(cfg_q.irq_en)); // R7
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wake_q && stop_mode_i) |=> wake_q); // R9
    AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> $past(stop_mode_i)); // R9
    AST_WAKE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_q) |-> (lvl_acc && irq_q)); // R8
endmodule

// File: tb/vdet_xing_irq_bench.sv
module vdet_xing_irq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp = 1'b1;
    logic       stop = 1'b0;
    logic       we = 1'b0;
    logic [4:0] wdata = '0;
    logic [3:0] cfg;
    logic       flag, irq, wake;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // entry: {div_sel[1:0], new comparator level, expected flag}
    localparam logic [3:0] VEC [6] = '{
        4'b00_0_1, 4'b01_1_1, 4'b10_0_1, 4'b11_1_1, 4'b00_1_0, 4'b01_0_1
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    vdet_xing_irq u_vdet_xing_irq (
        .clk          (clk),
        .rst          (rst),
        .cmp_above_i  (cmp),
        .stop_mode_i  (stop),
        .ctrl_we_i    (we),
        .ctrl_wdata_i (wdata),
        .cfg_o        (cfg),
        .flag_o       (flag),
        .irq_o        (irq),
        .wake_o       (wake)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk);
        we    = 1'b1;
        wdata = d;
        @(negedge clk);
        we    = 1'b0;
    endtask

    // Forces a prescaler restart; returns at the negedge after the restarting edge.
    task automatic sync_div(input logic [1:0] sel, input logic wk, input logic ie);
        wr({1'b1, ~sel, wk, ie});
        wr({1'b1, sel, wk, ie});
    endtask

    task automatic run_xing(input logic [1:0] sel, input logic lvl, input int ef,
                            input int ei, input int ew, input string tag);
        int n;
        n   = 8 << sel;
        cmp = lvl;
        repeat (2*n - 1) @(negedge clk);
        chk({tag, " irq before 2N"}, irq, 0);
        chk({tag, " wake before 2N"}, wake, 0);
        @(negedge clk);
        chk({tag, " flag at 2N"}, flag, ef);
        chk({tag, " irq at 2N"}, irq, ei);
        chk({tag, " wake at 2N"}, wake, ew);
        @(negedge clk);
        chk({tag, " irq one cycle"}, irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cfg reset", cfg, 0);
        chk("R1 flag reset", flag, 0);
        chk("R1 irq reset", irq, 0);
        chk("R1 wake reset", wake, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 flag after release", flag, 0);

        wr(5'b1_10_1_1);
        chk("R2 cfg readback", cfg, 4'b10_1_1);

        // table: R3 periods per divider code, R5 both directions, R7 pulse
        foreach (VEC[i]) begin
            wr({1'b0, VEC[i][3:2], 1'b0, 1'b1});
            chk("R6 flag cleared by write", flag, 0);
            sync_div(VEC[i][3:2], 1'b0, 1'b1);
            run_xing(VEC[i][3:2], VEC[i][1], VEC[i][0], VEC[i][0], 0, "R3 R5 R7 table");
            repeat (20) @(negedge clk);
        end

        // R7: enable off, flag still sets, no request (level 0 -> 1)
        wr(5'b0_00_0_0);
        sync_div(2'b00, 1'b0, 1'b0);
        run_xing(2'b00, 1'b1, 1, 0, 0, "R7 enable off");

        // R4: single-tick glitch rejected
        wr(5'b0_00_0_1);
        sync_div(2'b00, 1'b0, 1'b1);
        cmp = 1'b0;
        repeat (8) @(negedge clk);
        cmp = 1'b1;
        repeat (16) @(negedge clk);
        chk("R4 glitch rejected flag", flag, 0);

        // R6: writing 1 to the flag bit does not set it
        wr(5'b1_00_0_1);
        chk("R6 write one ignored", flag, 0);

        // R8: set flag first, then wake from stop with flag already 1
        sync_div(2'b00, 1'b0, 1'b1);
        run_xing(2'b00, 1'b0, 1, 1, 0, "R5 fall sets flag");
        stop = 1'b1;
        sync_div(2'b00, 1'b1, 1'b1);
        run_xing(2'b00, 1'b1, 1, 1, 1, "R8 stop wake");
        repeat (30) @(negedge clk);
        chk("R9 wake held in stop", wake, 1);
        stop = 1'b0;
        chk("R9 wake before drop edge", wake, 1);
        @(negedge clk);
        chk("R9 wake cleared", wake, 0);

        // R10: falling in stop, and rising with wake enable off
        stop = 1'b1;
        sync_div(2'b00, 1'b1, 1'b1);
        run_xing(2'b00, 1'b0, 1, 0, 0, "R10 falling in stop");
        sync_div(2'b00, 1'b0, 1'b1);
        run_xing(2'b00, 1'b1, 1, 0, 0, "R10 wake enable off");
        stop = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule